// File: doc/BRIEF.md
# Page Remapping Lookup Cache

This block sits in front of a two-tier memory (a small fast tier and a large slow tier). It caches a few page pairings, each naming one slow-tier page and one fast-tier page whose contents have been exchanged. Every memory request presents its physical page number. The block answers with the page number where the data now lives. A request that matches either half of a cached pairing is redirected to the other half. A request that matches nothing passes through unchanged.

Swaps are whole-page operations and take many cycles. When a new pairing is installed, its entry is marked busy. The entry stays busy until the swap engine reports completion for that exact pairing. A lookup that lands on a busy entry raises a hold flag, so the request can wait until the data movement is finished.

The cache has a fixed number of sets with two ways each. One recency bit per set picks the victim. Pairings beyond the cached ones are kept elsewhere and are not part of this block.

Top module: `page_remap_cache`

## Requirements
- R1: After reset every entry is invalid. `resultValid`, `resultHit`, `resultHold` and `resultPage` read zero, and any lookup misses until an install.
- R2: The set is the low `SET_BITS` bits (2 by default, giving 4 sets) of the page number. An install goes to the set selected by its slow-tier page. A lookup searches only the set selected by its own page, so a page of another set never hits, even when it equals a cached page in its upper bits.
- R3: A lookup that matches the slow-tier field of a valid entry returns that entry's fast-tier page. A lookup that matches the fast-tier field returns the slow-tier page. In both cases `resultHit` is 1.
- R4: A lookup that matches no valid entry in its set returns its own page number, with `resultHit`=0 and `resultHold`=0.
- R5: An installed entry is busy. A lookup hit on a busy entry sets `resultHold`=1, and `resultHold` is never 1 without `resultHit`.
- R6: A completion whose slow and fast pages both equal those of a cached entry clears that entry's busy mark. A completion that matches no entry changes nothing.
- R7: The result registers load on the first rising edge after `lookupValid` is sampled high. `resultValid` is high for exactly that one cycle per lookup cycle.
- R8: An install with no matching entry fills way 0 of an empty set first, then way 1. When both ways are full, it replaces the way named by the set's recency bit. Every lookup hit and every install sets that bit to the way that was not touched.
- R9: An install whose slow-tier page is already cached in its set overwrites that entry in place. No set ever holds two valid entries with the same slow-tier page.
- R10: A lookup in the same cycle as an install or completion sees the table as it stood before that edge. If an install and a completion hit the same entry in the same cycle, the entry ends busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | A request page is presented this cycle |
| lookupPage | input | PAGE_W | Physical page number of the request |
| installValid | input | 1 | Record a new swap pairing |
| installSlow | input | PAGE_W | Slow-tier page of the new pairing |
| installFast | input | PAGE_W | Fast-tier page of the new pairing |
| doneValid | input | 1 | A swap has finished |
| doneSlow | input | PAGE_W | Slow-tier page of the finished swap |
| doneFast | input | PAGE_W | Fast-tier page of the finished swap |
| resultValid | output | 1 | Result registers hold a fresh answer |
| resultPage | output | PAGE_W | Redirected page number (or the request page on a miss) |
| resultHit | output | 1 | The request matched a cached pairing |
| resultHold | output | 1 | The matched pairing is still being swapped |

## Verification
The hardest state to reach from the ports is a full set in which the recency bit points away from the oldest install. Reaching it takes two installs followed by a hit on the first entry, so that a third install must evict the second. The bench builds this sequence in one set and then checks which pages still hit. It then re-installs an existing slow page to confirm the overwrite is in place and does not evict the other way. Same-edge collisions are driven by raising the install or completion strobe together with a lookup, then looking up again one cycle later.

// File: rtl/remap_pkg.sv
package remap_pkg;
  // strobes from control to datapath, one set per clock
  typedef struct packed {
    logic lookEn;
    logic lookHit;
    logic lookWay;
    logic lookFromSlow;
    logic instEn;
    logic instWay;
    logic doneEn;
    logic doneWay;
  } strobeT;
endpackage

// File: rtl/remap_ctrl.sv
module remap_ctrl
  import remap_pkg::*;
#(
  parameter int PAGE_W   = 16,
  parameter int SET_BITS = 2
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic                                   lookupValid,
  input  logic [PAGE_W-1:0]                      lookupPage,
  input  logic                                   installValid,
  input  logic [PAGE_W-1:0]                      installSlow,
  input  logic                                   doneValid,
  input  logic [PAGE_W-1:0]                      doneSlow,
  input  logic [PAGE_W-1:0]                      doneFast,
  input  logic [(1<<SET_BITS)-1:0][1:0]          validArr,
  input  logic [(1<<SET_BITS)-1:0][1:0][PAGE_W-1:0] slowArr,
  input  logic [(1<<SET_BITS)-1:0][1:0][PAGE_W-1:0] fastArr,
  input  logic [(1<<SET_BITS)-1:0]               lruArr,
  output strobeT                                 strobe
);
  localparam int SETS = 1 << SET_BITS;

  logic [SET_BITS-1:0] lkSet, inSet, dnSet;
  logic [1:0] lkSlowHit, lkFastHit, inMatch, dnMatch, lkAny;

  assign lkSet = lookupPage[SET_BITS-1:0];
  assign inSet = installSlow[SET_BITS-1:0];
  assign dnSet = doneSlow[SET_BITS-1:0];

  for (genvar w = 0; w < 2; w++) begin : g_way
    assign lkSlowHit[w] = validArr[lkSet][w] && (slowArr[lkSet][w] == lookupPage);
    assign lkFastHit[w] = validArr[lkSet][w] && (fastArr[lkSet][w] == lookupPage);
    assign inMatch[w]   = validArr[inSet][w] && (slowArr[inSet][w] == installSlow);
    assign dnMatch[w]   = validArr[dnSet][w] && (slowArr[dnSet][w] == doneSlow)
                          && (fastArr[dnSet][w] == doneFast);
  end

  assign lkAny = lkSlowHit | lkFastHit;

  always_comb begin
    strobe              = '0;
    strobe.lookEn       = lookupValid;
    strobe.lookHit      = lookupValid && (|lkAny);
    strobe.lookWay      = !lkAny[0];
    strobe.lookFromSlow = lkSlowHit[strobe.lookWay];
    strobe.instEn       = installValid;
    if (inMatch[0])                strobe.instWay = 1'b0;
    else if (inMatch[1])           strobe.instWay = 1'b1;
    else if (!validArr[inSet][0])  strobe.instWay = 1'b0;
    else if (!validArr[inSet][1])  strobe.instWay = 1'b1;
    else                           strobe.instWay = lruArr[inSet];
    strobe.doneEn       = doneValid && (|dnMatch);
    strobe.doneWay      = !dnMatch[0];
  end

  // R9: a set never carries the same slow page twice
  for (genvar s = 0; s < SETS; s++) begin : g_chk
    assert_unique_slow_R9: assert property (@(posedge clk) disable iff (!rstN)
      !(validArr[s][0] && validArr[s][1] && (slowArr[s][0] == slowArr[s][1])));
  end
endmodule

// File: rtl/remap_store.sv
module remap_store
  import remap_pkg::*;
#(
  parameter int PAGE_W   = 16,
  parameter int SET_BITS = 2
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  strobeT                                  strobe,
  input  logic [PAGE_W-1:0]                       lookupPage,
  input  logic [PAGE_W-1:0]                       installSlow,
  input  logic [PAGE_W-1:0]                       installFast,
  input  logic [PAGE_W-1:0]                       doneSlow,
  output logic [(1<<SET_BITS)-1:0][1:0]           validArr,
  output logic [(1<<SET_BITS)-1:0][1:0][PAGE_W-1:0] slowArr,
  output logic [(1<<SET_BITS)-1:0][1:0][PAGE_W-1:0] fastArr,
  output logic [(1<<SET_BITS)-1:0]                lruArr,
  output logic                                    resultValid,
  output logic [PAGE_W-1:0]                       resultPage,
  output logic                                    resultHit,
  output logic                                    resultHold
);
  localparam int SETS = 1 << SET_BITS;

  logic [SETS-1:0][1:0] busyArr;
  logic [SET_BITS-1:0] lkSet, inSet, dnSet;
  logic [PAGE_W-1:0] partner;

  assign lkSet = lookupPage[SET_BITS-1:0];
  assign inSet = installSlow[SET_BITS-1:0];
  assign dnSet = doneSlow[SET_BITS-1:0];
  assign partner = strobe.lookFromSlow ? fastArr[lkSet][strobe.lookWay]
                                       : slowArr[lkSet][strobe.lookWay];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validArr    <= '0;
      slowArr     <= '0;
      fastArr     <= '0;
      busyArr     <= '0;
      lruArr      <= '0;
      resultValid <= 1'b0;
      resultPage  <= '0;
      resultHit   <= 1'b0;
      resultHold  <= 1'b0;
    end else begin
      resultValid <= strobe.lookEn;
      if (strobe.lookEn) begin
        resultHit  <= strobe.lookHit;
        resultHold <= strobe.lookHit && busyArr[lkSet][strobe.lookWay];
        resultPage <= strobe.lookHit ? partner : lookupPage;
      end
      if (strobe.lookHit) lruArr[lkSet] <= ~strobe.lookWay;
      if (strobe.doneEn) busyArr[dnSet][strobe.doneWay] <= 1'b0;
      if (strobe.instEn) begin
        validArr[inSet][strobe.instWay] <= 1'b1;
        slowArr[inSet][strobe.instWay]  <= installSlow;
        fastArr[inSet][strobe.instWay]  <= installFast;
        busyArr[inSet][strobe.instWay]  <= 1'b1;
        lruArr[inSet]                   <= ~strobe.instWay;
      end
    end
  end

  assert_hold_needs_hit_R5: assert property (@(posedge clk) disable iff (!rstN)
    resultHold |-> resultHit);
  assert_install_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.instEn |=> busyArr[$past(inSet)][$past(strobe.instWay)]);
  assert_one_cycle_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lookEn |=> resultValid);
  assert_no_stray_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.lookEn |=> !resultValid);
  assert_miss_passthrough_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.lookEn && !strobe.lookHit) |=> (resultPage == $past(lookupPage)) && !resultHold);
  assert_lru_flip_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.lookHit && !strobe.instEn) |=> (lruArr[$past(lkSet)] != $past(strobe.lookWay)));
endmodule

// File: rtl/page_remap_cache.sv
module page_remap_cache
  import remap_pkg::*;
#(
  parameter int PAGE_W   = 16,
  parameter int SET_BITS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [PAGE_W-1:0] lookupPage,
  input  logic              installValid,
  input  logic [PAGE_W-1:0] installSlow,
  input  logic [PAGE_W-1:0] installFast,
  input  logic              doneValid,
  input  logic [PAGE_W-1:0] doneSlow,
  input  logic [PAGE_W-1:0] doneFast,
  output logic              resultValid,
  output logic [PAGE_W-1:0] resultPage,
  output logic              resultHit,
  output logic              resultHold
);
  localparam int SETS = 1 << SET_BITS;

  strobeT strobe;
  logic [SETS-1:0][1:0]             validArr;
  logic [SETS-1:0][1:0][PAGE_W-1:0] slowArr;
  logic [SETS-1:0][1:0][PAGE_W-1:0] fastArr;
  logic [SETS-1:0]                  lruArr;

  remap_ctrl #(.PAGE_W(PAGE_W), .SET_BITS(SET_BITS)) uCtrl (
    .clk(clk), .rstN(rstN),
    .lookupValid(lookupValid), .lookupPage(lookupPage),
    .installValid(installValid), .installSlow(installSlow),
    .doneValid(doneValid), .doneSlow(doneSlow), .doneFast(doneFast),
    .validArr(validArr), .slowArr(slowArr), .fastArr(fastArr), .lruArr(lruArr),
    .strobe(strobe)
  );

  remap_store #(.PAGE_W(PAGE_W), .SET_BITS(SET_BITS)) uStore (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .lookupPage(lookupPage), .installSlow(installSlow), .installFast(installFast),
    .doneSlow(doneSlow),
    .validArr(validArr), .slowArr(slowArr), .fastArr(fastArr), .lruArr(lruArr),
    .resultValid(resultValid), .resultPage(resultPage),
    .resultHit(resultHit), .resultHold(resultHold)
  );
endmodule

// File: tb/sim_page_remap_cache.sv
`timescale 1ns/1ps
module sim_page_remap_cache;
  localparam int PAGE_W = 16;

  typedef struct packed {
    logic [1:0]  op;      // 0 lookup, 1 install, 2 done
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] expPage;
    logic        expHit;
    logic        expHold;
  } vecT;

  localparam int NVEC = 12;
  localparam vecT VEC [NVEC] = '{
    '{2'd0, 16'h0010, 16'h0000, 16'h0010, 1'b0, 1'b0},  // R4 empty miss
    '{2'd1, 16'h1001, 16'h0021, 16'h0000, 1'b0, 1'b0},  // install set 1
    '{2'd0, 16'h1001, 16'h0000, 16'h0021, 1'b1, 1'b1},  // R3 slow->fast, R5 hold
    '{2'd0, 16'h0021, 16'h0000, 16'h1001, 1'b1, 1'b1},  // R3 fast->slow
    '{2'd2, 16'h1001, 16'h0025, 16'h0000, 1'b0, 1'b0},  // R6 wrong pair
    '{2'd0, 16'h1001, 16'h0000, 16'h0021, 1'b1, 1'b1},  // R6 still busy
    '{2'd2, 16'h1001, 16'h0021, 16'h0000, 1'b0, 1'b0},  // R6 matching completion
    '{2'd0, 16'h0021, 16'h0000, 16'h1001, 1'b1, 1'b0},  // R6 busy cleared
    '{2'd0, 16'h1002, 16'h0000, 16'h1002, 1'b0, 1'b0},  // R2 other set misses
    '{2'd0, 16'h1005, 16'h0000, 16'h1005, 1'b0, 1'b0},  // R2 same set other page
    '{2'd1, 16'h2002, 16'h0042, 16'h0000, 1'b0, 1'b0},  // install set 2
    '{2'd0, 16'h0042, 16'h0000, 16'h2002, 1'b1, 1'b1}   // R3 R5
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lookupValid = 1'b0, installValid = 1'b0, doneValid = 1'b0;
  logic [PAGE_W-1:0] lookupPage = '0, installSlow = '0, installFast = '0;
  logic [PAGE_W-1:0] doneSlow = '0, doneFast = '0;
  logic resultValid, resultHit, resultHold;
  logic [PAGE_W-1:0] resultPage;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  page_remap_cache #(.PAGE_W(PAGE_W), .SET_BITS(2)) u0 (
    .clk(clk), .rstN(rstN),
    .lookupValid(lookupValid), .lookupPage(lookupPage),
    .installValid(installValid), .installSlow(installSlow), .installFast(installFast),
    .doneValid(doneValid), .doneSlow(doneSlow), .doneFast(doneFast),
    .resultValid(resultValid), .resultPage(resultPage),
    .resultHit(resultHit), .resultHold(resultHold)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic expectResult(string req, logic [15:0] page, logic hit, logic hold);
    check({req, " valid"}, {31'd0, resultValid}, 32'd1);
    check({req, " page"}, {16'd0, resultPage}, {16'd0, page});
    check({req, " hit"}, {31'd0, resultHit}, {31'd0, hit});
    check({req, " hold"}, {31'd0, resultHold}, {31'd0, hold});
  endtask

  task automatic lookup(string req, logic [15:0] p, logic [15:0] page, logic hit, logic hold);
    @(negedge clk); lookupValid = 1'b1; lookupPage = p;
    @(negedge clk); lookupValid = 1'b0;
    expectResult(req, page, hit, hold);
  endtask

  task automatic install(logic [15:0] s, logic [15:0] f);
    @(negedge clk); installValid = 1'b1; installSlow = s; installFast = f;
    @(negedge clk); installValid = 1'b0;
  endtask

  task automatic complete(logic [15:0] s, logic [15:0] f);
    @(negedge clk); doneValid = 1'b1; doneSlow = s; doneFast = f;
    @(negedge clk); doneValid = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    doReset();
    // R1 reset state
    check("R1 valid", {31'd0, resultValid}, 32'd0);
    check("R1 hit", {31'd0, resultHit}, 32'd0);
    check("R1 hold", {31'd0, resultHold}, 32'd0);
    check("R1 page", {16'd0, resultPage}, 32'd0);

    // table walk (R2 R3 R4 R5 R6)
    for (int i = 0; i < NVEC; i++) begin
      case (VEC[i].op)
        2'd1: install(VEC[i].a, VEC[i].b);
        2'd2: complete(VEC[i].a, VEC[i].b);
        default: lookup($sformatf("table vector %0d", i), VEC[i].a,
                        VEC[i].expPage, VEC[i].expHit, VEC[i].expHold);
      endcase
    end

    // R7: valid for exactly one cycle after the request
    @(negedge clk); lookupValid = 1'b1; lookupPage = 16'h0042;
    check("R7 not before edge", {31'd0, resultValid}, 32'd0);
    @(negedge clk); lookupValid = 1'b0;
    check("R7 valid after one edge", {31'd0, resultValid}, 32'd1);
    @(negedge clk);
    check("R7 valid drops", {31'd0, resultValid}, 32'd0);

    // R8 replacement in set 3
    install(16'h1003, 16'h0033);   // way0
    install(16'h2003, 16'h0043);   // way1, recency -> way0
    lookup("R8 touch first", 16'h1003, 16'h0033, 1'b1, 1'b1);  // recency -> way1
    install(16'h3003, 16'h0053);   // evicts 0x2003
    lookup("R8 evicted", 16'h2003, 16'h2003, 1'b0, 1'b0);
    lookup("R8 kept", 16'h0033, 16'h1003, 1'b1, 1'b1);          // recency -> way1
    lookup("R8 new", 16'h3003, 16'h0053, 1'b1, 1'b1);           // recency -> way0
    install(16'h4003, 16'h0063);   // evicts 0x1003
    lookup("R8 second eviction", 16'h1003, 16'h1003, 1'b0, 1'b0);
    lookup("R8 newest", 16'h0063, 16'h4003, 1'b1, 1'b1);

    // R9 in-place overwrite
    install(16'h3003, 16'h0073);
    lookup("R9 old partner gone", 16'h0053, 16'h0053, 1'b0, 1'b0);
    lookup("R9 new partner", 16'h3003, 16'h0073, 1'b1, 1'b1);
    lookup("R9 neighbour kept", 16'h4003, 16'h0063, 1'b1, 1'b1);

    // R10 same-edge install and lookup
    @(negedge clk); installValid = 1'b1; installSlow = 16'h1000; installFast = 16'h0020;
    lookupValid = 1'b1; lookupPage = 16'h1000;
    @(negedge clk); installValid = 1'b0; lookupValid = 1'b0;
    expectResult("R10 lookup sees old table", 16'h1000, 1'b0, 1'b0);
    lookup("R10 visible next cycle", 16'h1000, 16'h0020, 1'b1, 1'b1);
    // R10 same-edge completion and lookup
    @(negedge clk); doneValid = 1'b1; doneSlow = 16'h2002; doneFast = 16'h0042;
    lookupValid = 1'b1; lookupPage = 16'h0042;
    @(negedge clk); doneValid = 1'b0; lookupValid = 1'b0;
    expectResult("R10 still busy at edge", 16'h2002, 1'b1, 1'b1);
    lookup("R10 cleared after edge", 16'h0042, 16'h2002, 1'b1, 1'b0);
    // R10 install and completion of the same entry together: stays busy
    @(negedge clk); doneValid = 1'b1; doneSlow = 16'h1000; doneFast = 16'h0020;
    installValid = 1'b1; installSlow = 16'h1000; installFast = 16'h0020;
    @(negedge clk); doneValid = 1'b0; installValid = 1'b0;
    lookup("R10 install wins", 16'h1000, 16'h0020, 1'b1, 1'b1);

    // R1 reset clears the table
    doReset();
    check("R1 valid after reset", {31'd0, resultValid}, 32'd0);
    lookup("R1 table empty", 16'h1001, 16'h1001, 1'b0, 1'b0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule